// File: doc/BRIEF.md
# Reciprocal Multiply Coefficient Quantizer

This block quantizes signed transform coefficients that arrive in groups of 64, one group per 8x8 image block. Dividing by a quantization step would need a divider. Instead, each coefficient is multiplied by a stored reciprocal of its step, scaled by 2^13, and the product is shifted right by 13 bits. The block accepts one coefficient per clock. Each coefficient comes with a valid strobe and a position index in the range 0 to 63. The result leaves a fixed four-stage pipeline together with the same strobe and index.

The 64 reciprocals sit in a small register table. The table is loaded through an address/data/write-enable port while no coefficients are in flight. After reset every entry holds 8192, which stands for a step of 1 and passes coefficients through unchanged apart from saturation.

Negative coefficients are handled on their magnitude. The magnitude is rounded half away from zero, and the sign is then restored. This makes the quantizer symmetric about zero. Results are clamped to a signed 12-bit range.

Top module: `coef_quantizer`

## Requirements
- R1: A coefficient presented with `in_vld` high before clock edge k appears on the outputs with `out_vld` high after edge k+3, exactly four edges later. One coefficient may be accepted on every cycle, and `out_vld` is never high without a matching input.
- R2: `out_idx` equals the `in_idx` that was presented with the same coefficient.
- R3: For a non-negative coefficient x at position p, the result is floor((x * T[p] + 4096) / 8192). T[p] is the unsigned 16-bit table entry for p.
- R4: For a negative coefficient x, the result is the negation of the R3 result computed on |x|, so that -x always yields the negation of the result for x.
- R5: A positive result above 2047 is replaced by 2047. A negative result below -2048 is replaced by -2048. The full input range (-32768 to 32767) is accepted.
- R6: A cycle with `tbl_we` high stores `tbl_data` into entry `tbl_addr`. Later coefficients at that position use the new value, and the other entries keep their values.
- R7: A synchronous active-high `rst` clears `out_vld` and every internal valid bit on the next edge. It also sets all 64 table entries to 8192, so a coefficient within the 12-bit range comes out unchanged.
- R8: A zero coefficient gives a zero result for any table entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input coefficient valid |
| in_idx | input | 6 | Position of the input coefficient within its block |
| in_coef | input | 16 | Signed input coefficient |
| tbl_we | input | 1 | Reciprocal table write enable |
| tbl_addr | input | 6 | Reciprocal table entry to write |
| tbl_data | input | 16 | Unsigned reciprocal (2^13 / step) to store |
| out_vld | output | 1 | Result valid |
| out_idx | output | 6 | Position of the result |
| out_coef | output | 12 | Signed quantized result |

## Verification
On every cycle, the assertions check the following:
- `out_vld` and `out_idx` follow `in_vld` and `in_idx` by exactly four edges.
- Reset leaves the output idle.
- A zero coefficient produces zero.
- A nonzero result carries the sign of its input.

The scoreboard bench covers what depends on the table contents:
- the rounding of exact halves in both signs;
- clamping at both ends of the range;
- the pass-through default after reset;
- a table write changing only the addressed position.

// File: rtl/coef_quantizer.sv
module coef_quantizer #(
  parameter int IN_W    = 16,
  parameter int RECIP_W = 16,
  parameter int SHIFT   = 13,
  parameter int OUT_W   = 12,
  parameter int N_COEF  = 64,
  localparam int IDX_W  = $clog2(N_COEF)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_vld,
  input  logic [IDX_W-1:0]        in_idx,
  input  logic signed [IN_W-1:0]  in_coef,
  input  logic                    tbl_we,
  input  logic [IDX_W-1:0]        tbl_addr,
  input  logic [RECIP_W-1:0]      tbl_data,
  output logic                    out_vld,
  output logic [IDX_W-1:0]        out_idx,
  output logic signed [OUT_W-1:0] out_coef
);

  localparam int PROD_W = IN_W + RECIP_W;
  localparam int Q_W    = PROD_W + 1 - SHIFT;
  localparam logic [RECIP_W-1:0] UNITY = RECIP_W'(1 << SHIFT);
  localparam logic [PROD_W:0]    HALF  = (PROD_W+1)'(1) << (SHIFT - 1);
  localparam logic [Q_W-1:0]     POS_LIM = Q_W'((1 << (OUT_W - 1)) - 1);
  localparam logic [Q_W-1:0]     NEG_LIM = Q_W'(1 << (OUT_W - 1));

  logic [RECIP_W-1:0] tbl [N_COEF];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_COEF; i++) tbl[i] <= UNITY;
    end else if (tbl_we) begin
      tbl[tbl_addr] <= tbl_data;
    end
  end

  logic             neg_in;
  logic [IN_W-1:0]  mag_in;
  assign neg_in = in_coef[IN_W-1];
  assign mag_in = neg_in ? IN_W'(-in_coef) : IN_W'(in_coef);

  logic              s1_vld, s2_vld, s3_vld;
  logic [IDX_W-1:0]  s1_idx, s2_idx, s3_idx;
  logic              s1_neg, s2_neg, s3_neg;
  logic [IN_W-1:0]   s1_mag;
  logic [PROD_W-1:0] s2_prod, s3_prod;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld  <= 1'b0;
      s2_vld  <= 1'b0;
      s3_vld  <= 1'b0;
      out_vld <= 1'b0;
    end else begin
      s1_vld  <= in_vld;
      s2_vld  <= s1_vld;
      s3_vld  <= s2_vld;
      out_vld <= s3_vld;
    end
  end

  logic [PROD_W:0]  rnd;
  logic [Q_W-1:0]   q_mag, q_sat;
  logic [OUT_W-1:0] q_low, q_res;

  assign rnd   = {1'b0, s3_prod} + HALF;
  assign q_mag = rnd[PROD_W:SHIFT];
  assign q_sat = s3_neg ? ((q_mag > NEG_LIM) ? NEG_LIM : q_mag)
                        : ((q_mag > POS_LIM) ? POS_LIM : q_mag);
  assign q_low = q_sat[OUT_W-1:0];
  assign q_res = s3_neg ? (~q_low + 1'b1) : q_low;

  always_ff @(posedge clk) begin
    s1_idx   <= in_idx;
    s1_neg   <= neg_in;
    s1_mag   <= mag_in;
    s2_idx   <= s1_idx;
    s2_neg   <= s1_neg;
    s2_prod  <= PROD_W'(s1_mag) * PROD_W'(tbl[s1_idx]);
    s3_idx   <= s2_idx;
    s3_neg   <= s2_neg;
    s3_prod  <= s2_prod;
    out_idx  <= s3_idx;
    out_coef <= q_res;
  end

endmodule

// File: rtl/coef_quantizer_chk.sv
module coef_quantizer_chk #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 12,
  parameter int IDX_W = 6
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_vld,
  input logic [IDX_W-1:0]        in_idx,
  input logic signed [IN_W-1:0]  in_coef,
  input logic                    out_vld,
  input logic [IDX_W-1:0]        out_idx,
  input logic signed [OUT_W-1:0] out_coef
);

  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= 3'd0;
    else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
  end

  logic warm;
  assign warm = (since_rst == 3'd4);

  a_r1_vld_latency: assert property (@(posedge clk) disable iff (rst)
    warm |-> (out_vld == $past(in_vld, 4)));

  a_r2_idx_follows: assert property (@(posedge clk) disable iff (rst)
    (warm && out_vld) |-> (out_idx == $past(in_idx, 4)));

  a_r4_sign_kept: assert property (@(posedge clk) disable iff (rst)
    (warm && out_vld && out_coef != '0) |-> (out_coef[OUT_W-1] == $past(in_coef[IN_W-1], 4)));

  a_r7_reset_idle: assert property (@(posedge clk)
    rst |=> !out_vld);

  a_r8_zero_in_zero_out: assert property (@(posedge clk) disable iff (rst)
    (warm && out_vld && $past(in_coef, 4) == '0) |-> (out_coef == '0));

endmodule

bind coef_quantizer coef_quantizer_chk #(
  .IN_W(IN_W), .OUT_W(OUT_W), .IDX_W(IDX_W)
) chk_i (
  .clk(clk), .rst(rst), .in_vld(in_vld), .in_idx(in_idx), .in_coef(in_coef),
  .out_vld(out_vld), .out_idx(out_idx), .out_coef(out_coef)
);

// File: tb/coef_quantizer_tb.sv
module coef_quantizer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_vld = 1'b0;
  logic [5:0]        in_idx = '0;
  logic signed [15:0] in_coef = '0;
  logic              tbl_we = 1'b0;
  logic [5:0]        tbl_addr = '0;
  logic [15:0]       tbl_data = '0;
  logic              out_vld;
  logic [5:0]        out_idx;
  logic signed [11:0] out_coef;

  coef_quantizer dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_idx(in_idx), .in_coef(in_coef),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .out_vld(out_vld), .out_idx(out_idx), .out_coef(out_coef)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;
  int model_tbl [64];
  int q_idx [$];
  int q_val [$];
  int q_cyc [$];
  string q_tag [$];

  function automatic int model(int x, int r);
    longint m, p, q;
    m = (x < 0) ? -x : x;
    p = m * r;
    q = (p + 4096) >>> 13;
    if (x < 0) return (q > 2048) ? -2048 : -int'(q);
    return (q > 2047) ? 2047 : int'(q);
  endfunction

  task automatic check(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic send(int idx, int x, string tag);
    @(negedge clk);
    in_vld  = 1'b1;
    in_idx  = 6'(idx);
    in_coef = 16'(x);
    q_idx.push_back(idx);
    q_val.push_back(model(x, model_tbl[idx]));
    q_cyc.push_back(cyc);
    q_tag.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 1'b0;
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    in_vld   = 1'b0;
    tbl_we   = 1'b1;
    tbl_addr = 6'(a);
    tbl_data = 16'(d);
    model_tbl[a] = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst && out_vld) begin
        if (q_val.size() == 0) begin
          check("R1 unexpected out_vld", 1, 0);
        end else begin
          int ei, ev, ec;
          string et;
          ei = q_idx.pop_front();
          ev = q_val.pop_front();
          ec = q_cyc.pop_front();
          et = q_tag.pop_front();
          check("R1 latency", cyc - ec, 4);
          check("R2 index", int'(out_idx), ei);
          check(et, int'(out_coef), ev);
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) model_tbl[i] = 8192;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R7 out_vld after reset", int'(out_vld), 0);

    // R7: default table passes coefficients through
    for (int i = 0; i < 64; i++) send(i, i * 37 - 1100, "R7 identity");
    send(3, 2047, "R7 max pass");
    send(4, -2048, "R7 min pass");
    send(5, 2048, "R5 clamp high");
    send(6, -2049, "R5 clamp low");
    send(7, 0, "R8 zero");
    idle(6);

    // R6: load a full table of reciprocals for steps 1..64
    for (int i = 0; i < 64; i++) wr(i, 8192 / (i + 1));
    idle(2);
    for (int i = 0; i < 64; i++) begin
      send(i, (i * 523) % 4001 - 2000, "R3 scaled");
      if (i % 5 == 4) idle(1);
    end
    idle(6);

    // R4: symmetric rounding of exact halves, step 16
    wr(15, 512);
    send(15, 1000, "R4 pos half");
    send(15, -1000, "R4 neg half");
    send(15, 8, "R4 pos half small");
    send(15, -8, "R4 neg half small");
    send(15, 7, "R3 below half");
    send(15, -7, "R4 below half neg");
    send(15, 0, "R8 zero scaled");
    idle(6);

    // R5: extreme inputs with largest reciprocal
    wr(0, 65535);
    send(0, 32767, "R5 sat pos");
    send(0, -32768, "R5 sat neg");
    send(0, 1, "R3 small");
    idle(6);

    // R6: one write touches one entry only
    wr(5, 3000);
    send(5, 100, "R6 new entry");
    send(6, 100, "R6 neighbour kept");
    send(4, -100, "R6 neighbour kept neg");
    idle(10);
    check("R1 all results produced", q_val.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule